// File: doc/BRIEF.md
# Overlay Scaler Step Calculator

This block turns a source rectangle and a destination rectangle into the programming words that a video overlay scaler needs. It takes the source width and height, the destination width and height, and the source left and top positions in 16.16 fixed point. It also takes two display-mode flags, one for line doubling and one for interlaced output. A start pulse launches one calculation. A single shared restoring divider produces the vertical increment and then the raw horizontal increment, one quotient bit per cycle. A normalisation loop then halves the horizontal increment until it is below 2.0 and counts how many pixels the scaler must step per fetch.

When the calculation ends, the block registers a packed increment word carrying a luma field and a half-rate chroma field, a packed step word, two horizontal accumulator seeds (luma and chroma) and a vertical accumulator seed. A one-cycle done pulse marks the words as valid, and they hold until the next done. A zero divisor is caught before any division begins. It raises an error flag and the words are forced to zero.

Top module: `ovl_step_calc`

## Requirements
- R1: After reset, every output word is zero and done, err and busy are low.
- R2: The effective destination height is twice dst_h when dbl_scan is high (whatever interlace is). It is dst_h shifted right by one when only interlace is high, and dst_h when neither flag is set.
- R3: v_inc equals (src_h << 20) divided by the effective destination height, truncated to 32 bits.
- R4: The raw horizontal increment is (src_w << 12) / dst_w in 4.12 format. Starting from a step count of 1, each halving of the increment adds one to the count while the increment is at least 0x2000. There are at most 8 halvings, so the count never exceeds 9.
- R5: h_inc_word holds the final increment h in bits [15:0] and h >> 1 in bits [31:16].
- R6: step_word holds the step count in bits [7:0] and again in bits [15:8].
- R7: With t = (left_fx & 0x3FFFF) + 0x28000 + (h << 3), luma_hseed is ((t << 4) & 0x000F8000) | ((t << 12) & 0xF0000000).
- R8: With u = ((left_fx >> 1) & 0x1FFFF) + 0x28000 + (h << 2), chroma_hseed is ((u << 4) & 0x000F8000) | ((u << 12) & 0x70000000).
- R9: With w = (top_fx & 0xFFFF) + 0x18000, vseed is (w << 4) with bit 0 set.
- R10: If dst_w is zero or the effective destination height is zero, err goes high with done and every output word is zero. This includes a height of 1 with only interlace set.
- R11: done is a single-cycle pulse. Output words change only in the done cycle and hold between pulses. A start while busy is ignored. A start in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a calculation when idle |
| src_w | input | DIM_W | Source width in pixels |
| src_h | input | DIM_W | Source height in lines |
| dst_w | input | DIM_W | Destination width in pixels |
| dst_h | input | DIM_W | Destination height in lines |
| left_fx | input | 32 | Source left position, 16.16 |
| top_fx | input | 32 | Source top position, 16.16 |
| dbl_scan | input | 1 | Output is line doubled |
| interlace | input | 1 | Output is interlaced |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| err | output | 1 | Last calculation had a zero divisor |
| v_inc | output | 32 | Vertical increment, 12.20 |
| h_inc_word | output | 32 | Packed luma/chroma horizontal increment |
| step_word | output | 16 | Packed step count |
| luma_hseed | output | 32 | Luma horizontal accumulator seed |
| chroma_hseed | output | 32 | Chroma horizontal accumulator seed |
| vseed | output | 32 | Vertical accumulator seed |

## Verification
The done pulse of one calculation and the acceptance of the next start can fall in the same cycle. The bench provokes this by raising start with new dimensions on the clock in which it sees done. It then judges that the old words stay on the outputs while the second run is busy, and that the second done delivers the new words. A start raised in the middle of a run is also checked to leave that run's results untouched. The eight-halving bound is reached with a 4000-to-1 horizontal ratio.

// File: rtl/ovl_step_calc.sv
module ovl_step_calc #(
  parameter int DIM_W     = 12,
  parameter int MAX_HALVE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIM_W-1:0] src_w,
  input  logic [DIM_W-1:0] src_h,
  input  logic [DIM_W-1:0] dst_w,
  input  logic [DIM_W-1:0] dst_h,
  input  logic [31:0]      left_fx,
  input  logic [31:0]      top_fx,
  input  logic             dbl_scan,
  input  logic             interlace,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [31:0]      v_inc,
  output logic [31:0]      h_inc_word,
  output logic [15:0]      step_word,
  output logic [31:0]      luma_hseed,
  output logic [31:0]      chroma_hseed,
  output logic [31:0]      vseed
);
  localparam int ACC_W  = 32;
  localparam int CNT_W  = $clog2(ACC_W);
  localparam int HCNT_W = $clog2(MAX_HALVE + 1);
  localparam int V_FRAC = 20;
  localparam int H_FRAC = 12;

  typedef enum logic [2:0] {S_IDLE, S_DIVV, S_DIVH, S_NORM, S_FIN} st_t;
  st_t st;

  logic [DIM_W:0]     dvs;
  logic [DIM_W+1:0]   rem;
  logic [ACC_W-1:0]   quo;
  logic [CNT_W-1:0]   cnt;
  logic [ACC_W-1:0]   h_val, v_q;
  logic [HCNT_W-1:0]  hcnt;
  logic [7:0]         step;
  logic [31:0]        left_q, top_q;
  logic [DIM_W-1:0]   sw_q, dw_q;
  logic               err_q;

  wire [DIM_W:0] eff_h = dbl_scan  ? {dst_h, 1'b0} :
                         interlace ? {2'b00, dst_h[DIM_W-1:1]} :
                                     {1'b0, dst_h};

  wire [DIM_W+1:0] rem_sh   = {rem[DIM_W:0], quo[ACC_W-1]};
  wire             fits     = rem_sh >= {1'b0, dvs};
  wire [DIM_W+1:0] rem_nx   = fits ? rem_sh - {1'b0, dvs} : rem_sh;
  wire [ACC_W-1:0] quo_nx   = {quo[ACC_W-2:0], fits};
  wire             div_last = cnt == CNT_W'(ACC_W - 1);

  wire [31:0] lt = (left_q & 32'h0003_FFFF) + 32'h0002_8000 + (h_val << 3);
  wire [31:0] ct = ((left_q >> 1) & 32'h0001_FFFF) + 32'h0002_8000 + (h_val << 2);
  wire [31:0] vt = (top_q & 32'h0000_FFFF) + 32'h0001_8000;

  assign busy = st != S_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      dvs <= '0; rem <= '0; quo <= '0; cnt <= '0;
      h_val <= '0; v_q <= '0; hcnt <= '0; step <= '0;
      left_q <= '0; top_q <= '0; sw_q <= '0; dw_q <= '0; err_q <= 1'b0;
      done <= 1'b0; err <= 1'b0;
      v_inc <= '0; h_inc_word <= '0; step_word <= '0;
      luma_hseed <= '0; chroma_hseed <= '0; vseed <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          left_q <= left_fx;
          top_q  <= top_fx;
          sw_q   <= src_w;
          dw_q   <= dst_w;
          if (eff_h == '0 || dst_w == '0) begin
            err_q <= 1'b1;
            st    <= S_FIN;
          end else begin
            err_q <= 1'b0;
            quo   <= ACC_W'(src_h) << V_FRAC;
            rem   <= '0;
            dvs   <= eff_h;
            cnt   <= '0;
            st    <= S_DIVV;
          end
        end
        S_DIVV: begin
          rem <= rem_nx;
          quo <= quo_nx;
          cnt <= cnt + 1'b1;
          if (div_last) begin
            v_q <= quo_nx;
            quo <= ACC_W'(sw_q) << H_FRAC;
            rem <= '0;
            dvs <= {1'b0, dw_q};
            st  <= S_DIVH;
          end
        end
        S_DIVH: begin
          rem <= rem_nx;
          quo <= quo_nx;
          cnt <= cnt + 1'b1;
          if (div_last) begin
            h_val <= quo_nx;
            step  <= 8'd1;
            hcnt  <= '0;
            st    <= S_NORM;
          end
        end
        S_NORM: begin
          if (h_val >= 32'h0000_2000 && hcnt != HCNT_W'(MAX_HALVE)) begin
            h_val <= h_val >> 1;
            step  <= step + 8'd1;
            hcnt  <= hcnt + 1'b1;
          end else begin
            st <= S_FIN;
          end
        end
        S_FIN: begin
          done <= 1'b1;
          err  <= err_q;
          st   <= S_IDLE;
          if (err_q) begin
            v_inc <= '0; h_inc_word <= '0; step_word <= '0;
            luma_hseed <= '0; chroma_hseed <= '0; vseed <= '0;
          end else begin
            v_inc        <= v_q;
            h_inc_word   <= h_val | ((h_val >> 1) << 16);
            step_word    <= {step, step};
            luma_hseed   <= ((lt << 4) & 32'h000F_8000) | ((lt << 12) & 32'hF000_0000);
            chroma_hseed <= ((ct << 4) & 32'h000F_8000) | ((ct << 12) & 32'h7000_0000);
            vseed        <= (vt << 4) | 32'h1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ovl_step_calc_chk.sv
module ovl_step_calc_chk #(
  parameter int MAX_HALVE = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        err,
  input logic        busy,
  input logic [31:0] v_inc,
  input logic [31:0] h_inc_word,
  input logic [15:0] step_word,
  input logic [31:0] luma_hseed,
  input logic [31:0] chroma_hseed,
  input logic [31:0] vseed
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11

  AST_WORDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(v_inc) && $stable(h_inc_word) && $stable(step_word) &&
               $stable(luma_hseed) && $stable(chroma_hseed) && $stable(vseed))); // R11

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (v_inc == 0 && h_inc_word == 0 && step_word == 0 &&
                       luma_hseed == 0 && chroma_hseed == 0 && vseed == 0)); // R10

  AST_STEP_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (step_word[15:8] == step_word[7:0] && step_word[7:0] >= 8'd1 &&
                        step_word[7:0] <= 8'(MAX_HALVE + 1))); // R6

  AST_HWORD_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (h_inc_word[31:16] == {1'b0, h_inc_word[15:1]})); // R5

  AST_VSEED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (vseed[3:0] == 4'b0001)); // R9

  AST_SEED_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((luma_hseed & 32'h0FF0_7FFF) == 0 && (chroma_hseed & 32'h8FF0_7FFF) == 0)); // R8
endmodule

bind ovl_step_calc ovl_step_calc_chk #(.MAX_HALVE(MAX_HALVE)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .err(err), .busy(busy),
  .v_inc(v_inc), .h_inc_word(h_inc_word), .step_word(step_word),
  .luma_hseed(luma_hseed), .chroma_hseed(chroma_hseed), .vseed(vseed)
);

// File: tb/ovl_step_calc_bench.sv
`timescale 1ns/1ps
module ovl_step_calc_bench;
  localparam int DIM_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DIM_W-1:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
  logic [31:0] left_fx = '0, top_fx = '0;
  logic dbl_scan = 1'b0, interlace = 1'b0;
  logic busy, done, err;
  logic [31:0] v_inc, h_inc_word, luma_hseed, chroma_hseed, vseed;
  logic [15:0] step_word;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] e_v, e_hw, e_ls, e_cs, e_vs;
  logic [15:0] e_sw;
  logic        e_err;

  always #2 clk = ~clk;

  ovl_step_calc #(.DIM_W(DIM_W), .MAX_HALVE(8)) u_ovl_step_calc (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
    .left_fx(left_fx), .top_fx(top_fx), .dbl_scan(dbl_scan), .interlace(interlace),
    .busy(busy), .done(done), .err(err),
    .v_inc(v_inc), .h_inc_word(h_inc_word), .step_word(step_word),
    .luma_hseed(luma_hseed), .chroma_hseed(chroma_hseed), .vseed(vseed)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [DIM_W-1:0] sw, sh, dw, dh,
                       input logic [31:0] l, t, input logic dbl, il);
    logic [31:0] eff, raw, h, lt, ct, vt;
    logic [7:0] st;
    if (dbl) eff = 32'(dh) * 2;
    else if (il) eff = 32'(dh) >> 1;
    else eff = 32'(dh);
    if (eff == 0 || dw == 0) begin
      e_err = 1'b1; e_v = 0; e_hw = 0; e_sw = 0; e_ls = 0; e_cs = 0; e_vs = 0;
    end else begin
      e_err = 1'b0;
      e_v = (32'(sh) << 20) / eff;
      raw = (32'(sw) << 12) / 32'(dw);
      h = raw; st = 8'd1;
      for (int i = 0; i < 8; i++)
        if (h >= 32'h2000) begin h = h >> 1; st = st + 8'd1; end
      e_hw = h | ((h >> 1) << 16);
      e_sw = {st, st};
      lt = (l & 32'h3FFFF) + 32'h28000 + (h << 3);
      e_ls = ((lt << 4) & 32'h000F8000) | ((lt << 12) & 32'hF0000000);
      ct = ((l >> 1) & 32'h1FFFF) + 32'h28000 + (h << 2);
      e_cs = ((ct << 4) & 32'h000F8000) | ((ct << 12) & 32'h70000000);
      vt = (t & 32'hFFFF) + 32'h18000;
      e_vs = (vt << 4) | 32'h1;
    end
  endtask

  task automatic drive(input logic [DIM_W-1:0] sw, sh, dw, dh,
                       input logic [31:0] l, t, input logic dbl, il);
    src_w = sw; src_h = sh; dst_w = dw; dst_h = dh;
    left_fx = l; top_fx = t; dbl_scan = dbl; interlace = il;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL %s: watchdog, done actual 0 expected 1", tag);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R10 err"}, 32'(err), 32'(e_err));
    chk({tag, " R3 v_inc"}, v_inc, e_v);
    chk({tag, " R4 R5 h_inc_word"}, h_inc_word, e_hw);
    chk({tag, " R6 step_word"}, 32'(step_word), 32'(e_sw));
    chk({tag, " R7 luma_hseed"}, luma_hseed, e_ls);
    chk({tag, " R8 chroma_hseed"}, chroma_hseed, e_cs);
    chk({tag, " R9 vseed"}, vseed, e_vs);
  endtask

  task automatic run_case(input string tag, input logic [DIM_W-1:0] sw, sh, dw, dh,
                          input logic [31:0] l, t, input logic dbl, il);
    model(sw, sh, dw, dh, l, t, dbl, il);
    drive(sw, sh, dw, dh, l, t, dbl, il);
    wait_done(tag);
    check_all(tag);
    @(negedge clk);
    chk({tag, " R11 done single"}, 32'(done), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 done", 32'(done), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 v_inc", v_inc, 0);
    chk("R1 h_inc_word", h_inc_word, 0);
    chk("R1 step_word", 32'(step_word), 0);
    chk("R1 seeds", luma_hseed | chroma_hseed | vseed, 0);
  endtask

  task automatic t_upscale;
    run_case("up R2 R3", 12'd320, 12'd240, 12'd640, 12'd480, 32'h0003_8000, 32'h0001_4000, 1'b0, 1'b0);
  endtask

  task automatic t_downscale;
    run_case("down R4", 12'd1280, 12'd720, 12'd200, 12'd150, 32'h0012_C000, 32'h0007_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_modes;
    run_case("dblscan R2", 12'd352, 12'd288, 12'd704, 12'd300, 32'h0, 32'h0, 1'b1, 1'b0);
    run_case("interlace R2", 12'd720, 12'd576, 12'd720, 12'd576, 32'h0001_0000, 32'h0000_8000, 1'b0, 1'b1);
    run_case("both R2", 12'd640, 12'd480, 12'd640, 12'd101, 32'h0, 32'h0, 1'b1, 1'b1);
  endtask

  task automatic t_bound;
    run_case("bound R4", 12'd4000, 12'd7, 12'd1, 12'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
    chk("bound R4 step 9", 32'(step_word[7:0]), 32'd9);
  endtask

  task automatic t_zero;
    run_case("zero dst_w R10", 12'd100, 12'd100, 12'd0, 12'd50, 32'h0, 32'h0, 1'b0, 1'b0);
    run_case("interlace h1 R10", 12'd100, 12'd100, 12'd50, 12'd1, 32'h0, 32'h0, 1'b0, 1'b1);
    run_case("recover R10", 12'd100, 12'd100, 12'd50, 12'd1, 32'h0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_busy_ignore;
    model(12'd500, 12'd400, 12'd250, 12'd800, 32'h0002_0000, 32'h0003_0000, 1'b0, 1'b0);
    drive(12'd500, 12'd400, 12'd250, 12'd800, 32'h0002_0000, 32'h0003_0000, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R11 busy mid-run", 32'(busy), 32'd1);
    drive(12'd9, 12'd9, 12'd3, 12'd3, 32'h5555_5555, 32'h1234_5678, 1'b1, 1'b0);
    wait_done("busy R11");
    check_all("busy R11");
    repeat (3) @(negedge clk);
    chk("R11 held v_inc", v_inc, e_v);
    chk("R11 held luma", luma_hseed, e_ls);
  endtask

  task automatic t_back_to_back;
    logic [31:0] old_v;
    model(12'd800, 12'd600, 12'd1024, 12'd768, 32'h0, 32'h0, 1'b0, 1'b0);
    drive(12'd800, 12'd600, 12'd1024, 12'd768, 32'h0, 32'h0, 1'b0, 1'b0);
    wait_done("b2b first R11");
    check_all("b2b first R11");
    old_v = e_v;
    model(12'd100, 12'd90, 12'd37, 12'd61, 32'h0000_C000, 32'h0000_0001, 1'b0, 1'b1);
    drive(12'd100, 12'd90, 12'd37, 12'd61, 32'h0000_C000, 32'h0000_0001, 1'b0, 1'b1);
    chk("b2b R11 accepted busy", 32'(busy), 32'd1);
    chk("b2b R11 done low", 32'(done), 32'd0);
    chk("b2b R11 old held", v_inc, old_v);
    wait_done("b2b second R11");
    check_all("b2b second R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: global timeout actual expired expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_upscale();
    t_downscale();
    t_modes();
    t_bound();
    t_zero();
    t_busy_ignore();
    t_back_to_back();
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule